// File: doc/BRIEF.md
# Port Bit Pattern-Match Detector

This block watches a parallel input port, one clock sample per cycle, and decides whether the port shows a programmed pattern. Each bit can first be inverted by a per-bit data inversion mask. Three configuration vectors, called select, edge and sense, then set a condition for each bit. A bit can be ignored, or it can match any change, a low or high level, or a falling or rising edge. Edges are found by comparing the inverted sample with the one taken on the previous clock.

A two-bit mode input combines the per-bit results. AND mode needs every active bit to hold in the same cycle. OR mode needs any one bit to hold. Priority OR mode also reports the index of the highest-numbered matching bit. A sticky match flag records each hit until a clear strobe removes it. The block also keeps a captured copy of the inverted port. When capture-on-match is enabled, that copy freezes on the matching sample and is released by the clear.

Top module: `pattern_match_det`

## Requirements
- R1: While reset is low and on the first cycle after it, match_flag is 0, match_idx is 0 and data_q is 0.
- R2: Every bit of the port is XORed with inv_mask before it is matched or captured. A 1 inverts the bit and a 0 passes it through.
- R3: A bit with sel=1 and edge=0 holds when its inverted value equals its sense bit (sense 0 = low level, sense 1 = high level).
- R4: A bit with sel=1 and edge=1 holds on a rising edge when sense is 1, and on a falling edge when sense is 0. The edge is taken between the previous clock's inverted sample and the current one. No edge is seen on the first sample after reset.
- R5: A bit with sel=0 and edge=1 holds on any change of its inverted value since the previous clock.
- R6: A bit with sel=0 and edge=0 is ignored. In AND mode it never blocks a match. If every bit is ignored, AND mode never matches.
- R7: Mode 2'b01 (AND) matches when every non-ignored bit holds in the same cycle.
- R8: Mode 2'b10 (OR) matches when at least one bit holds.
- R9: Mode 2'b00 disables matching, so match_flag never rises.
- R10: Mode 2'b11 (priority OR) matches as OR does and puts the highest-numbered holding bit on match_idx. While the flag is pending, a later match replaces the index only when its index is higher.
- R11: A match sets match_flag on the next clock edge. The flag stays set until match_clr is sampled high. If a match and a clear fall in the same cycle, the flag stays set.
- R12: When not frozen, data_q takes the inverted port on every clock. With capture_en high, a match freezes data_q at the matching sample. The clear releases it, and on that clock data_q reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_in | input | W | Monitored port |
| inv_mask | input | W | Per-bit input inversion |
| pat_sel | input | W | Per-bit select vector |
| pat_edge | input | W | Per-bit edge vector |
| pat_sense | input | W | Per-bit sense (polarity) vector |
| mode | input | 2 | 00 off, 01 AND, 10 OR, 11 priority OR |
| capture_en | input | 1 | Freeze data_q on a match |
| match_clr | input | 1 | Clears flag, index and freeze |
| match_flag | output | 1 | Sticky match flag |
| match_idx | output | IW | Highest matching bit index (priority OR) |
| data_q | output | W | Captured, inverted port value |

## Verification
A clear strobe can arrive in the same cycle as a fresh match. In that case the new event must win, and in priority mode it must load its index freshly rather than be compared with the one being cleared. The bench first drops the flag with a clear that comes alone. It then raises match_clr while the port holds a matching level. It expects match_flag to stay set, and it expects the frozen data to be released on that clear and reloaded. The coincident clear in capture mode is judged in the same way, by reading data_q and the flag after the shared edge.

// File: rtl/pattern_match_det.sv
module pattern_match_det #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  port_in,
  input  logic [W-1:0]  inv_mask,
  input  logic [W-1:0]  pat_sel,
  input  logic [W-1:0]  pat_edge,
  input  logic [W-1:0]  pat_sense,
  input  logic [1:0]    mode,
  input  logic          capture_en,
  input  logic          match_clr,
  output logic          match_flag,
  output logic [IW-1:0] match_idx,
  output logic [W-1:0]  data_q
);

  localparam logic [1:0] M_OFF = 2'b00;
  localparam logic [1:0] M_AND = 2'b01;
  localparam logic [1:0] M_OR  = 2'b10;
  localparam logic [1:0] M_PRI = 2'b11;

  logic [W-1:0]  adj, prev, rise, fall, lvl, edg, cond, active;
  logic          prev_vld, frozen, hit, pending, hold, upd_idx;
  logic [IW-1:0] cand;

  assign adj    = port_in ^ inv_mask;
  assign rise   = {W{prev_vld}} & adj & ~prev;
  assign fall   = {W{prev_vld}} & ~adj & prev;
  assign lvl    = ~(adj ^ pat_sense);
  assign edg    = (pat_sense & rise) | (~pat_sense & fall);
  assign active = pat_sel | pat_edge;
  assign cond   = (pat_sel & ((~pat_edge & lvl) | (pat_edge & edg)))
                | (~pat_sel & pat_edge & (rise | fall));

  always_comb begin
    unique case (mode)
      M_AND:       hit = (|active) && (&(cond | ~active));
      M_OR, M_PRI: hit = |cond;
      default:     hit = 1'b0;
    endcase
  end

  always_comb begin
    cand = '0;
    for (int i = 0; i < W; i++)
      if (cond[i]) cand = IW'(i);
  end

  assign pending = match_flag && !match_clr;
  assign hold    = frozen && !match_clr;
  assign upd_idx = (mode == M_PRI) && hit && (!pending || cand > match_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev       <= '0;
      prev_vld   <= 1'b0;
      match_flag <= 1'b0;
      match_idx  <= '0;
      data_q     <= '0;
      frozen     <= 1'b0;
    end else begin
      prev     <= adj;
      prev_vld <= 1'b1;
      if (hit)            match_flag <= 1'b1;
      else if (match_clr) match_flag <= 1'b0;
      if (upd_idx)        match_idx <= cand;
      else if (match_clr) match_idx <= '0;
      if (!hold)          data_q <= adj;
      if (capture_en && hit && !hold) frozen <= 1'b1;
      else if (match_clr)             frozen <= 1'b0;
    end
  end

  // R11
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> match_flag);
  // R11
  clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && match_clr) |=> !match_flag);
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !match_clr) |=> $stable(match_flag));
  // R12
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !match_clr) |=> $stable(data_q));
  // R10
  idx_rises_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_PRI && match_flag && !match_clr) |=> (match_idx >= $past(match_idx)));
  // R9
  off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && !match_clr) |=> $stable(match_flag));
  // R6
  all_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_AND && active == '0) |-> !hit);

endmodule

// File: tb/pattern_match_det_tb.sv
module pattern_match_det_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NV = 15;

  // fields: tag, mode, sel, edge, sense, inv, prev_in, cur_in, flag, idx
  localparam logic [57:0] VEC [NV] = '{
    {4'd7,  2'd1, 8'h0F, 8'h00, 8'h05, 8'h00, 8'h00, 8'h05, 1'b1, 3'd0}, // R7 R3
    {4'd7,  2'd1, 8'h0F, 8'h00, 8'h05, 8'h00, 8'h00, 8'h07, 1'b0, 3'd0}, // R7 R3
    {4'd2,  2'd1, 8'h0F, 8'h00, 8'h05, 8'hFF, 8'h00, 8'hFA, 1'b1, 3'd0}, // R2
    {4'd4,  2'd1, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 1'b1, 3'd0}, // R4 rise
    {4'd4,  2'd1, 8'h01, 8'h01, 8'h01, 8'h00, 8'h01, 8'h01, 1'b0, 3'd0}, // R4 no edge
    {4'd4,  2'd1, 8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 3'd0}, // R4 fall
    {4'd5,  2'd2, 8'h00, 8'h80, 8'h00, 8'h00, 8'h80, 8'h00, 1'b1, 3'd0}, // R5
    {4'd5,  2'd2, 8'h00, 8'h80, 8'h00, 8'h00, 8'h80, 8'h80, 1'b0, 3'd0}, // R5
    {4'd6,  2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 3'd0}, // R6 all ignored
    {4'd8,  2'd2, 8'h03, 8'h00, 8'h03, 8'h00, 8'h00, 8'h02, 1'b1, 3'd0}, // R8
    {4'd7,  2'd1, 8'h03, 8'h00, 8'h03, 8'h00, 8'h00, 8'h02, 1'b0, 3'd0}, // R7
    {4'd9,  2'd0, 8'h0F, 8'h00, 8'h05, 8'h00, 8'h00, 8'h05, 1'b0, 3'd0}, // R9
    {4'd10, 2'd3, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h24, 1'b1, 3'd5}, // R10
    {4'd6,  2'd1, 8'h01, 8'h00, 8'h01, 8'h00, 8'h00, 8'hF1, 1'b1, 3'd0}, // R6 ignored bits
    {4'd10, 2'd3, 8'hF0, 8'hF0, 8'hF0, 8'h00, 8'h00, 8'h30, 1'b1, 3'd5}  // R10 edges
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] port_in = '0, inv_mask = '0, pat_sel = '0, pat_edge = '0, pat_sense = '0;
  logic [1:0] mode = 2'd0;
  logic capture_en = 1'b0, match_clr = 1'b0;
  logic match_flag;
  logic [2:0] match_idx;
  logic [W-1:0] data_q;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_match_det #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .inv_mask(inv_mask),
    .pat_sel(pat_sel), .pat_edge(pat_edge), .pat_sense(pat_sense), .mode(mode),
    .capture_en(capture_en), .match_clr(match_clr), .match_flag(match_flag),
    .match_idx(match_idx), .data_q(data_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    port_in = 8'h01; pat_sel = 8'h01; pat_edge = 8'h01; pat_sense = 8'h01; mode = 2'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 flag", match_flag, 0);
    check("R1 idx", match_idx, 0);
    check("R1 data", data_q, 0);
    rst_n = 1'b1;
    step();
    check("R4 no edge after reset", match_flag, 0);
    step();
    check("R4 no edge held", match_flag, 0);

    for (int k = 0; k < NV; k++) begin
      logic [57:0] v;
      v = VEC[k];
      mode = 2'd0; match_clr = 1'b1;
      pat_sel = v[51:44]; pat_edge = v[43:36]; pat_sense = v[35:28]; inv_mask = v[27:20];
      port_in = v[19:12];
      step();
      match_clr = 1'b0; mode = v[53:52]; port_in = v[11:4];
      step();
      check($sformatf("R%0d vec%0d flag", v[57:54], k), match_flag, v[3]);
      check($sformatf("R%0d vec%0d idx", v[57:54], k), match_idx, v[2:0]);
      check($sformatf("R12 vec%0d data", k), data_q, v[11:4] ^ v[27:20]);
    end

    // R10 replacement only by higher index
    mode = 2'd0; match_clr = 1'b1; inv_mask = 0;
    pat_sel = 8'hFF; pat_edge = 8'h00; pat_sense = 8'hFF; port_in = 8'h00;
    step();
    match_clr = 1'b0; mode = 2'd3; port_in = 8'h24;
    step();
    check("R10 first idx", match_idx, 5);
    port_in = 8'h08;
    step();
    check("R10 lower kept", match_idx, 5);
    port_in = 8'h80;
    step();
    check("R10 higher replaces", match_idx, 7);

    // R11 sticky flag and coincident clear
    mode = 2'd1; match_clr = 1'b1; pat_sel = 8'h01; pat_sense = 8'h01; port_in = 8'h00;
    step();
    check("R11 cleared", match_flag, 0);
    match_clr = 1'b0; port_in = 8'h01;
    step();
    check("R11 set", match_flag, 1);
    port_in = 8'h00;
    repeat (3) step();
    check("R11 sticky", match_flag, 1);
    match_clr = 1'b1;
    step();
    check("R11 clear alone", match_flag, 0);
    port_in = 8'h01;
    step();
    check("R11 clear with hit", match_flag, 1);

    // R12 capture on match
    match_clr = 1'b1; port_in = 8'h10; capture_en = 1'b1;
    step();
    check("R12 follow", data_q, 8'h10);
    match_clr = 1'b0; port_in = 8'h31;
    step();
    check("R12 capture flag", match_flag, 1);
    check("R12 capture", data_q, 8'h31);
    port_in = 8'h42;
    step();
    check("R12 frozen", data_q, 8'h31);
    port_in = 8'h53;
    step();
    check("R12 frozen on rehit", data_q, 8'h31);
    match_clr = 1'b1; port_in = 8'h71;
    step();
    check("R12 clear with hit reloads", data_q, 8'h71);
    check("R11 flag kept", match_flag, 1);
    port_in = 8'h62;
    step();
    check("R12 released", data_q, 8'h62);
    check("R11 flag dropped", match_flag, 0);
    match_clr = 1'b0; capture_en = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule